// File: doc/BRIEF.md
# Merging Posted Write Buffer

This block sits between the shared master-side request port and a 32-bit memory controller. Writes of any byte width are posted into a small queue of doubleword slots and acknowledged in the cycle they are presented. A write whose doubleword already sits in a queued slot that has not started its memory write is folded into that slot lane by lane. A stream of single-byte writes therefore leaves the block as whole-doubleword memory writes. Slots are written back to memory in allocation order, in the background, while the master side is idle or busy elsewhere.

Reads are never delayed by a flush. Every read address is compared against all queued slots. The read is sent to memory ahead of any queued write-back that has not yet started, and the bytes held in matching slots replace the matching lanes of the returned word. When several slots hold the same doubleword, the most recently written byte of each lane wins. An enable input selects a pass-through mode instead: each write is then sent straight to memory, and the master port stays busy until the memory has completed it.

Top module: `merge_post_wbuf`

## Requirements
- R1: After reset the memory request and the read-data valid output are low, and with the enable high and the queue empty the master ready output is high for a write.
- R2: With the enable high and a free slot, a write is accepted in the cycle it is presented, before any memory activity for it has finished.
- R3: A write to the doubleword of a queued slot whose memory write has not started takes no new slot. Its enabled lanes overwrite that slot's bytes, and the slot's byte-enable mask becomes the union of both masks.
- R4: Sixty-four single-byte writes presented back to back to ascending addresses of a 64-byte aligned region produce exactly sixteen memory writes, each with all four byte enables set (enable bit n covers data bits 8n+7 to 8n) and carrying the written bytes.
- R5: The oldest slot starts its memory write once all four of its lanes are set, or another slot is queued behind it, or no write enters the queue in that cycle. Slots reach memory in allocation order.
- R6: A read whose doubleword is queued is sent to memory without first writing the queue back. Each lane held by a matching slot replaces the corresponding returned byte, and every other lane carries the memory data.
- R7: When two queued slots hold the same lane of the same doubleword, the read returns the byte from the slot allocated later.
- R8: A read presented while the matching slot's memory write is in progress returns that slot's bytes.
- R9: With every slot occupied, a write that cannot fold into a slot sees master ready low until a slot's memory write completes.
- R10: With the enable low, a write is accepted only when the queue is empty and the memory port is free. It is issued to memory with the master's address, byte enables and data, and master ready stays low until the memory acknowledges it.
- R11: Read data is valid for exactly one cycle, the cycle after the memory acknowledges the read, and master ready stays low for every request while a read is outstanding.
- R12: A memory request keeps its address, direction, byte enables and write data unchanged until the memory acknowledges it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | High: post and merge writes; low: pass writes straight through |
| m_req | input | 1 | Master request present |
| m_we | input | 1 | Master request is a write (1) or a read (0) |
| m_addr | input | AW | Master doubleword address |
| m_be | input | DW/8 | Master byte enables, bit n selects data bits 8n+7..8n |
| m_wdata | input | DW | Master write data |
| m_ready | output | 1 | Request accepted at the rising edge where m_req and this are high |
| m_rvalid | output | 1 | Read data valid, one-cycle pulse |
| m_rdata | output | DW | Read data with buffered bytes merged in |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory doubleword address |
| mem_be | output | DW/8 | Memory byte enables |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
The bench builds the block with a 6-bit doubleword address, 32-bit data and a four-slot queue. The memory model then covers all 64 words, so every write-back can be checked against a word computed in the bench. The small address space allows a sweep of all fifteen non-zero byte-enable patterns against forwarded reads. With only four slots, the full-queue stall is reached with five writes. Adjustable memory latency opens the windows for reads during a write-back and for two slots sharing one doubleword.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_READ  = 2'd2,
        ST_BYP   = 2'd3
    } mpw_fsm_e;
endpackage

// File: rtl/mpw_lane_mux.sv
module mpw_lane_mux #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   base,
    input  logic [DW-1:0]   ovr,
    input  logic [DW/8-1:0] sel,
    output logic [DW-1:0]   out
);
    localparam int LN = DW / 8;

    for (genvar gl = 0; gl < LN; gl++) begin : g_lane
        assign out[gl*8 +: 8] = sel[gl] ? ovr[gl*8 +: 8] : base[gl*8 +: 8];
    end
endmodule

// File: rtl/mpw_slots.sv
module mpw_slots #(
    parameter int DEPTH = 4,
    parameter int AW    = 30,
    parameter int DW    = 32,
    localparam int LN   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_dw,
    input  logic [LN-1:0] wr_be,
    input  logic [DW-1:0] wr_data,
    input  logic          lock_head,
    input  logic          pop,
    output logic          hit,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] head_dw,
    output logic [LN-1:0] head_be,
    output logic [DW-1:0] head_data,
    input  logic [AW-1:0] snp_dw,
    output logic [LN-1:0] snp_mask,
    output logic [DW-1:0] snp_data
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] dw;
        logic [DEPTH-1:0][LN-1:0] be;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [CW-1:0]            cnt;
    } slots_t;

    slots_t q, d;
    logic [PW-1:0]    slot_age [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] hit_v;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        assign slot_age[gi] = PW'(gi) - q.head;
        assign vld[gi]      = CW'(slot_age[gi]) < q.cnt;
        assign hit_v[gi]    = vld[gi] && (q.dw[gi] == wr_dw)
                              && !(lock_head && (PW'(gi) == q.head));
    end

    assign hit       = |hit_v;
    assign cnt       = q.cnt;
    assign head_dw   = q.dw[q.head];
    assign head_be   = q.be[q.head];
    assign head_data = q.data[q.head];

    // Next state: fold, allocate, retire
    always_comb begin
        logic [PW-1:0] tail;
        d    = q;
        tail = q.head + PW'(q.cnt);
        if (wr_en) begin
            if (hit) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (hit_v[i]) begin
                        for (int l = 0; l < LN; l++) begin
                            if (wr_be[l]) d.data[i][l*8 +: 8] = wr_data[l*8 +: 8];
                        end
                        d.be[i] = q.be[i] | wr_be;
                    end
                end
            end else begin
                d.dw[tail]   = wr_dw;
                d.be[tail]   = wr_be;
                d.data[tail] = wr_data;
            end
        end
        if (pop) d.head = q.head + PW'(1);
        d.cnt = q.cnt + CW'(wr_en && !hit) - CW'(pop);
    end

    // Self-snoop: walk oldest to youngest so later slots override
    always_comb begin
        logic [PW-1:0] idx;
        snp_mask = '0;
        snp_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = q.head + PW'(k);
            if ((CW'(k) < q.cnt) && (q.dw[idx] == snp_dw)) begin
                for (int l = 0; l < LN; l++) begin
                    if (q.be[idx][l]) begin
                        snp_mask[l]          = 1'b1;
                        snp_data[l*8 +: 8]   = q.data[idx][l*8 +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |-> (q.cnt < CW'(DEPTH)));
    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_v));
    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q.cnt != '0));
endmodule

// File: rtl/merge_post_wbuf.sv
module merge_post_wbuf #(
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            m_req,
    input  logic            m_we,
    input  logic [AW-1:0]   m_addr,
    input  logic [DW/8-1:0] m_be,
    input  logic [DW-1:0]   m_wdata,
    output logic            m_ready,
    output logic            m_rvalid,
    output logic [DW-1:0]   m_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata
);
    import mpw_pkg::*;

    localparam int LN = DW / 8;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        mpw_fsm_e      fsm;
        logic          rd_pend;
        logic [AW-1:0] addr;
        logic [LN-1:0] be;
        logic [DW-1:0] wdata;
        logic [LN-1:0] fmask;
        logic [DW-1:0] fdata;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t q, d;

    logic          hit, pop, lock_head, buf_wr;
    logic          acc_r, acc_w, rd_busy, can_buf, can_byp;
    logic [CW-1:0] cnt;
    logic [AW-1:0] head_dw;
    logic [LN-1:0] head_be, snp_mask;
    logic [DW-1:0] head_data, snp_data, merged;

    assign lock_head = (q.fsm == ST_DRAIN);
    assign rd_busy   = q.rd_pend || (q.fsm == ST_READ);
    assign can_buf   = en && (hit || (cnt != CW'(DEPTH)));
    assign can_byp   = !en && (cnt == '0) && (q.fsm == ST_IDLE);
    assign m_ready   = !rd_busy && (q.fsm != ST_BYP)
                       && (m_we ? (can_buf || can_byp) : 1'b1);
    assign acc_w     = m_req && m_ready && m_we;
    assign acc_r     = m_req && m_ready && !m_we;
    assign buf_wr    = acc_w && en;

    mpw_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr),
        .wr_dw     (m_addr),
        .wr_be     (m_be),
        .wr_data   (m_wdata),
        .lock_head (lock_head),
        .pop       (pop),
        .hit       (hit),
        .cnt       (cnt),
        .head_dw   (head_dw),
        .head_be   (head_be),
        .head_data (head_data),
        .snp_dw    (m_addr),
        .snp_mask  (snp_mask),
        .snp_data  (snp_data)
    );

    mpw_lane_mux #(.DW(DW)) u_fwd (
        .base (mem_rdata),
        .ovr  (q.fdata),
        .sel  (q.fmask),
        .out  (merged)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        pop      = 1'b0;
        unique case (q.fsm)
            ST_IDLE: begin
                if (acc_r) begin
                    d.fsm   = ST_READ;
                    d.addr  = m_addr;
                    d.be    = '1;
                    d.fmask = snp_mask;
                    d.fdata = snp_data;
                end else if (acc_w && !en) begin
                    d.fsm   = ST_BYP;
                    d.addr  = m_addr;
                    d.be    = m_be;
                    d.wdata = m_wdata;
                end else if (q.rd_pend) begin
                    d.fsm     = ST_READ;
                    d.rd_pend = 1'b0;
                end else if ((cnt != '0) && ((&head_be) || (cnt > CW'(1)) || !buf_wr)) begin
                    d.fsm = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (mem_ack) begin
                    pop   = 1'b1;
                    d.fsm = ST_IDLE;
                end
                if (acc_r) begin
                    d.rd_pend = 1'b1;
                    d.addr    = m_addr;
                    d.be      = '1;
                    d.fmask   = snp_mask;
                    d.fdata   = snp_data;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    d.fsm    = ST_IDLE;
                    d.rvalid = 1'b1;
                    d.rdata  = merged;
                end
            end
            default: begin
                if (mem_ack) d.fsm = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign m_rvalid  = q.rvalid;
    assign m_rdata   = q.rdata;
    assign mem_req   = (q.fsm != ST_IDLE);
    assign mem_we    = (q.fsm == ST_DRAIN) || (q.fsm == ST_BYP);
    assign mem_addr  = (q.fsm == ST_DRAIN) ? head_dw   : q.addr;
    assign mem_be    = (q.fsm == ST_DRAIN) ? head_be   : q.be;
    assign mem_wdata = (q.fsm == ST_DRAIN) ? head_data : q.wdata;

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_be) && $stable(mem_wdata)));
    a_r11_rvalid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |-> $past(mem_ack));
    a_r11_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |=> !m_rvalid);
    a_r10_bypass_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && m_req && m_we && m_ready) |=> (mem_req && mem_we && (mem_addr == $past(m_addr))));
endmodule

// File: tb/merge_post_wbuf_tb.sv
`timescale 1ns/1ps
module merge_post_wbuf_tb;
    logic        clk = 1'b0;
    logic        rst_n, en, m_req, m_we;
    logic [5:0]  m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wdata;
    logic        m_ready, m_rvalid;
    logic [31:0] m_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [5:0]  mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    merge_post_wbuf #(.AW(6), .DW(32), .DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model, acts on the falling edge
    logic [31:0] bmem [64];
    logic        ack;
    logic [31:0] rdq;
    int          lat, wcnt, nwr, bad_be;
    bit          want_full;

    assign mem_ack   = ack;
    assign mem_rdata = rdq;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bmem[i] = 32'h5EED_0000 ^ (32'(i) * 32'h0103_0507);
            ack = 1'b0; wcnt = 0; nwr = 0; bad_be = 0; rdq = '0;
        end else if (ack) begin
            ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                ack  = 1'b1;
                if (mem_we) begin
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) bmem[mem_addr][l*8 +: 8] = mem_wdata[l*8 +: 8];
                    nwr++;
                    if (want_full && mem_be != 4'hF) bad_be++;
                end else begin
                    rdq = bmem[mem_addr];
                end
            end else begin
                wcnt++;
            end
        end
    end

    function automatic logic [31:0] mrg(logic [31:0] b, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = b;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = n[l*8 +: 8];
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] dat, output int waits);
        m_req = 1'b1; m_we = 1'b1; m_addr = a; m_be = be; m_wdata = dat;
        #1;
        waits = 0;
        while (!m_ready) begin @(negedge clk); #1; waits++; end
        @(posedge clk);
        @(negedge clk);
        m_req = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] dat, output bit busy_ok, output bit pulse_ok);
        m_req = 1'b1; m_we = 1'b0; m_addr = a; m_be = 4'hF;
        #1;
        while (!m_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        m_req = 1'b0; m_we = 1'b1;
        #1 busy_ok = !m_ready;
        while (!m_rvalid) @(negedge clk);
        dat = m_rdata;
        @(negedge clk);
        pulse_ok = !m_rvalid;
    endtask

    task automatic quiet(int n);
        m_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w, n0;
        logic [31:0] got, base, dat;
        bit bo, po;
        rst_n = 1'b0; en = 1'b1; m_req = 1'b0; m_we = 1'b1; m_addr = '0; m_be = '0; m_wdata = '0;
        lat = 2; want_full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(m_ready == 1'b1, "R1 ready", 32'(m_ready), 1);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        chk(m_rvalid == 1'b0, "R1 rvalid", 32'(m_rvalid), 0);
        @(negedge clk);

        // R3: repeated lane takes the newest byte, single memory write
        n0 = nwr;
        wr(6'd3, 4'h1, 32'h0000_00AA, w); chk(w == 0, "R2 zero wait", 32'(w), 0);
        wr(6'd3, 4'h1, 32'h0000_00BB, w); chk(w == 0, "R2 zero wait", 32'(w), 0);
        wr(6'd3, 4'h2, 32'h0000_CC00, w);
        wr(6'd3, 4'h4, 32'h00DD_0000, w);
        wr(6'd3, 4'h8, 32'hEE00_0000, w);
        quiet(30);
        chk(nwr - n0 == 1, "R3 one write", 32'(nwr - n0), 1);
        chk(bmem[3] == 32'hEEDD_CCBB, "R3 merged word", bmem[3], 32'hEEDD_CCBB);

        // R4: 64 contiguous byte writes
        n0 = nwr; want_full = 1'b1;
        for (int b = 0; b < 64; b++) begin
            wr(6'(16 + b / 4), 4'(1 << (b % 4)), 32'(8'(b * 7 + 3)) << (8 * (b % 4)), w);
        end
        quiet(80);
        want_full = 1'b0;
        chk(nwr - n0 == 16, "R4 write count", 32'(nwr - n0), 16);
        chk(bad_be == 0, "R4 full enables", 32'(bad_be), 0);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] e;
            for (int l = 0; l < 4; l++) e[l*8 +: 8] = 8'((4 * k + l) * 7 + 3);
            chk(bmem[16 + k] == e, "R4 word", bmem[16 + k], e);
        end

        // R6 sweep over enable patterns, then R5 write-back
        lat = 3;
        for (int be = 1; be < 16; be++) begin
            for (int a = 40; a < 42; a++) begin
                quiet(30);
                base = bmem[a];
                n0   = nwr;
                dat  = 32'hA0B0_C0D0 ^ (32'(be) * 32'h0103_0507) ^ 32'(a);
                wr(6'(a), 4'(be), dat, w);
                rd(6'(a), got, bo, po);
                chk(got == mrg(base, dat, 4'(be)), "R6 forwarded read", got, mrg(base, dat, 4'(be)));
                chk(nwr == n0, "R6 no flush before read", 32'(nwr - n0), 0);
                quiet(30);
                chk(bmem[a] == mrg(base, dat, 4'(be)), "R5 written back", bmem[a], mrg(base, dat, 4'(be)));
            end
        end

        // R7 and R8: newer slot wins while the older one drains
        lat = 6;
        quiet(30);
        base = bmem[5];
        wr(6'd5, 4'h1, 32'h0000_00AA, w);
        @(negedge clk);
        chk(mem_req && mem_we, "R5 idle starts write-back", 32'(mem_req), 1);
        wr(6'd5, 4'h1, 32'h0000_00BB, w);
        rd(6'd5, got, bo, po);
        chk(got == {base[31:8], 8'hBB}, "R7 youngest lane", got, {base[31:8], 8'hBB});
        quiet(40);
        chk(bmem[5] == {base[31:8], 8'hBB}, "R5 allocation order", bmem[5], {base[31:8], 8'hBB});
        base = bmem[6];
        wr(6'd6, 4'h3, 32'h0000_5A5A, w);
        @(negedge clk);
        rd(6'd6, got, bo, po);
        chk(got == {base[31:16], 16'h5A5A}, "R8 read during write-back", got, {base[31:16], 16'h5A5A});

        // R9: full queue stalls a non-folding write
        lat = 10;
        quiet(40);
        n0 = nwr;
        for (int k = 0; k < 5; k++) begin
            wr(6'(48 + k), 4'h1, 32'(8'h60 + k), w);
            if (k < 4) chk(w == 0, "R2 free slot", 32'(w), 0);
            else       chk(w > 0, "R9 stall when full", 32'(w), 1);
        end
        quiet(100);
        chk(nwr - n0 == 5, "R9 write count", 32'(nwr - n0), 5);
        for (int k = 0; k < 5; k++)
            chk(bmem[48 + k][7:0] == 8'(8'h60 + k), "R9 data", 32'(bmem[48 + k][7:0]), 32'(8'h60 + k));

        // R10 and R12: pass-through write
        lat = 3; en = 1'b0;
        quiet(10);
        base = bmem[60];
        n0 = nwr;
        wr(6'd60, 4'b0110, 32'h1122_3344, w);
        #1;
        chk(mem_req && mem_we && mem_addr == 6'd60 && mem_be == 4'b0110, "R10 direct issue",
            {mem_req, mem_we, 20'd0, mem_addr, mem_be}, {2'b11, 20'd0, 6'd60, 4'b0110});
        m_we = 1'b1;
        chk(m_ready == 1'b0, "R10 busy until done", 32'(m_ready), 0);
        while (!m_ready) begin
            if (mem_req) chk(mem_addr == 6'd60, "R12 held address", 32'(mem_addr), 60);
            @(negedge clk); #1;
        end
        chk(nwr - n0 == 1, "R10 completed", 32'(nwr - n0), 1);
        chk(bmem[60] == mrg(base, 32'h1122_3344, 4'b0110), "R10 lanes", bmem[60], mrg(base, 32'h1122_3344, 4'b0110));
        @(negedge clk);
        en = 1'b1;

        // R11: response timing
        quiet(10);
        rd(6'd16, got, bo, po);
        chk(got == bmem[16], "R11 data", got, bmem[16]);
        chk(bo, "R11 busy while outstanding", 32'(bo), 1);
        chk(po, "R11 single pulse", 32'(po), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule